// File: doc/BRIEF.md
# Video Memory Access Port with Address Remap

This block gives a processor byte-wide register access to a word-organised video memory of 32K 16-bit words. The processor programs a control byte, writes a 16-bit word address as two separate bytes, and then either stores single bytes into the addressed word or reads bytes back out of a prefetched copy of it. Every access it makes to the memory goes through an optional rotation of the low address bits. This rotation lets tile data laid out row by row be stored in the interleaved order that a tile fetcher expects.

After an access to the chosen byte lane, the address register advances by a programmed step. The step is always applied to the plain, unrotated address, so a linear walk in software becomes a rotated walk in memory. Reads are served from a holding word that is refilled from memory after each address byte write and after each data read. The refill takes memory cycles, and the `ready` output tells the requester when it may issue the next access. The memory is a synchronous single-port word RAM with a one-cycle read latency and per-byte write enables.

Top module: `vram_port`

## Requirements
- R1: Control bits [1:0] pick the address step applied after an increment: 00 adds 1, 01 adds 32, and both 10 and 11 add 128. The address register is 16 bits wide and wraps.
- R2: Control bit 7 picks which access increments the address. When it is 0, a low-byte data write (select 3) or a low-byte read (`rd_hi`=0) increments. When it is 1, a high-byte data write (select 4) or a high-byte read increments. The other byte lane never moves the address.
- R3: With control bits [3:2] = 01, the low 8 bits of the address are rotated so that bits [7:5] land in bits [2:0] of `mem_addr`. Bits [4:0] move up to bits [7:3].
- R4: Control bits [3:2] = 10 apply the same 3-bit rotation over the low 9 bits. 11 applies it over the low 10 bits. 00 passes the address through unchanged. Bits above the rotated span are never altered.
- R5: A write to select 1 replaces address bits [7:0], and a write to select 2 replaces bits [15:8]. In the following cycle the port reads memory at the new address and places that word in the holding word.
- R6: A read request returns the low (`rd_hi`=0) or high byte of the holding word on `rd_data`, with `rd_valid` high, in the next cycle. The port then refills the holding word from the current address, and only after that applies any increment.
- R7: Address bit 15 never reaches the memory, so addresses that differ only in bit 15 select the same word.
- R8: A write to select 3 stores `reg_wdata` into the low byte lane of the word at the remapped address, with `mem_we`=01. A write to select 4 stores it into the high lane, with `mem_we`=10. The other lane keeps its contents.
- R9: The increment is applied to the stored address before any remap. The remap is recomputed from the stepped address for each later access.
- R10: After reset `ready` is 1 and the memory is idle. `ready` stays 1 after a control write, falls for one cycle after a data write, and falls for two cycles after an address write or a read. The memory is never accessed while `ready` is 1.
- R11: A data write does not refresh the holding word. A read after a write returns the word that was fetched before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, accepted when `ready` is 1 |
| reg_sel | input | 3 | Write target: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| reg_wdata | input | 8 | Write data byte |
| rd_req | input | 1 | Byte read request, accepted when `ready` is 1 and `reg_wr` is 0 |
| rd_hi | input | 1 | Read byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| ready | output | 1 | Port can accept a new request |
| mem_addr | output | 15 | Remapped physical word address |
| mem_rd | output | 1 | Memory read strobe, data returned one cycle later |
| mem_we | output | 2 | Byte lane write enables (bit 0 low lane, bit 1 high lane) |
| mem_wdata | output | 16 | Write data, the byte repeated on both lanes |
| mem_rdata | input | 16 | Memory read data |

## Verification
The assertions assume the requester never raises `reg_wr` and `rd_req` in the same cycle. They also assume every request is issued only in a cycle where `ready` is 1. The properties for refill gaps and lane enables depend on this, because a request made while the port is busy is simply not taken. The stimulus holds each request for exactly one cycle and, after each access, waits for `ready` to return before issuing the next one. It also drives the select codes only with the five defined values. Rotation spans, step sizes and increment lanes are all covered by the reference model's predictions, not by the properties.

// File: rtl/vp_pkg.sv
package vp_pkg;

    localparam int VP_AW  = 16;
    localparam int VP_DW  = 16;
    localparam int VP_BW  = 8;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_ADDR_LO = 3'd1;
    localparam logic [2:0] SEL_ADDR_HI = 3'd2;
    localparam logic [2:0] SEL_DATA_LO = 3'd3;
    localparam logic [2:0] SEL_DATA_HI = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_WRITE = 2'd3
    } vp_state_e;

    typedef struct packed {
        vp_state_e          st;
        logic [VP_AW-1:0]   addr;
        logic               inc_hi;
        logic [1:0]         step_sel;
        logic [1:0]         remap_sel;
        logic [VP_DW-1:0]   hold;
        logic [VP_BW-1:0]   wbyte;
        logic               wlane_hi;
        logic               inc_pend;
        logic [VP_BW-1:0]   rd_data;
        logic               rd_valid;
    } vp_regs_t;

endpackage

// File: rtl/vp_remap.sv
module vp_remap #(
    parameter int AW        = 15,
    parameter int ROT       = 3,
    parameter int BASE_SPAN = 8,
    parameter int NVAR      = 3
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] rot_v [NVAR];

    for (genvar g = 0; g < NVAR; g++) begin : g_span
        localparam int SPAN = BASE_SPAN + g;
        assign rot_v[g] = {addr_i[AW-1:SPAN],
                           addr_i[SPAN-ROT-1:0],
                           addr_i[SPAN-1:SPAN-ROT]};
    end

    always_comb begin
        case (mode_i)
            2'b01:   addr_o = rot_v[0];
            2'b10:   addr_o = rot_v[1];
            2'b11:   addr_o = rot_v[2];
            default: addr_o = addr_i;
        endcase
    end

endmodule

// File: rtl/vp_stepper.sv
module vp_stepper #(
    parameter int AW      = 16,
    parameter int MID_LOG = 5,
    parameter int BIG_LOG = 7
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    step_sel_i,
    input  logic          en_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] STEP_ONE = AW'(1);
    localparam logic [AW-1:0] STEP_MID = AW'(1) << MID_LOG;
    localparam logic [AW-1:0] STEP_BIG = AW'(1) << BIG_LOG;

    logic [AW-1:0] step;

    always_comb begin
        case (step_sel_i)
            2'b00:   step = STEP_ONE;
            2'b01:   step = STEP_MID;
            default: step = STEP_BIG;
        endcase
        addr_o = en_i ? (addr_i + step) : addr_i;
    end

endmodule

// File: rtl/vram_port.sv
module vram_port
    import vp_pkg::*;
#(
    parameter int AW     = vp_pkg::VP_AW,
    parameter int MEM_AW = AW - 1,
    parameter int DW     = vp_pkg::VP_DW,
    parameter int BW     = vp_pkg::VP_BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [BW-1:0]     reg_wdata,
    input  logic              rd_req,
    input  logic              rd_hi,
    output logic [BW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              ready,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic [1:0]        mem_we,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);

    localparam int LANES = DW / BW;

    vp_regs_t regs_d, regs_q;
    logic [AW-1:0] stepped;

    vp_stepper #(.AW(AW), .MID_LOG(5), .BIG_LOG(7)) u_step (
        .addr_i     (regs_q.addr),
        .step_sel_i (regs_q.step_sel),
        .en_i       (regs_q.inc_pend),
        .addr_o     (stepped)
    );

    vp_remap #(.AW(MEM_AW), .ROT(3), .BASE_SPAN(8), .NVAR(3)) u_remap (
        .addr_i (regs_q.addr[MEM_AW-1:0]),
        .mode_i (regs_q.remap_sel),
        .addr_o (mem_addr)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.rd_valid = 1'b0;
        case (regs_q.st)
            ST_IDLE: begin
                if (reg_wr) begin
                    case (reg_sel)
                        SEL_CTRL: begin
                            regs_d.inc_hi    = reg_wdata[7];
                            regs_d.remap_sel = reg_wdata[3:2];
                            regs_d.step_sel  = reg_wdata[1:0];
                        end
                        SEL_ADDR_LO: begin
                            regs_d.addr[BW-1:0] = reg_wdata;
                            regs_d.inc_pend     = 1'b0;
                            regs_d.st           = ST_FETCH;
                        end
                        SEL_ADDR_HI: begin
                            regs_d.addr[AW-1:BW] = reg_wdata;
                            regs_d.inc_pend      = 1'b0;
                            regs_d.st            = ST_FETCH;
                        end
                        SEL_DATA_LO: begin
                            regs_d.wbyte    = reg_wdata;
                            regs_d.wlane_hi = 1'b0;
                            regs_d.inc_pend = ~regs_q.inc_hi;
                            regs_d.st       = ST_WRITE;
                        end
                        SEL_DATA_HI: begin
                            regs_d.wbyte    = reg_wdata;
                            regs_d.wlane_hi = 1'b1;
                            regs_d.inc_pend = regs_q.inc_hi;
                            regs_d.st       = ST_WRITE;
                        end
                        default: ;
                    endcase
                end else if (rd_req) begin
                    regs_d.rd_data  = rd_hi ? regs_q.hold[DW-1:BW] : regs_q.hold[BW-1:0];
                    regs_d.rd_valid = 1'b1;
                    regs_d.inc_pend = (rd_hi == regs_q.inc_hi);
                    regs_d.st       = ST_FETCH;
                end
            end
            ST_FETCH: begin
                regs_d.addr     = stepped;
                regs_d.inc_pend = 1'b0;
                regs_d.st       = ST_LOAD;
            end
            ST_LOAD: begin
                regs_d.hold = mem_rdata;
                regs_d.st   = ST_IDLE;
            end
            ST_WRITE: begin
                regs_d.addr     = stepped;
                regs_d.inc_pend = 1'b0;
                regs_d.st       = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ready     = (regs_q.st == ST_IDLE);
    assign mem_rd    = (regs_q.st == ST_FETCH);
    assign mem_we    = (regs_q.st == ST_WRITE) ? (regs_q.wlane_hi ? 2'b10 : 2'b01) : 2'b00;
    assign mem_wdata = {LANES{regs_q.wbyte}};
    assign rd_data   = regs_q.rd_data;
    assign rd_valid  = regs_q.rd_valid;

endmodule

// File: rtl/vp_checker.sv
module vp_checker
    import vp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_sel,
    input logic        rd_req,
    input logic        rd_valid,
    input logic        ready,
    input logic        mem_rd,
    input logic [1:0]  mem_we
);

    // R5: an accepted address byte write is followed by a memory fetch
    p_addr_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready && reg_wr && (reg_sel == SEL_ADDR_LO || reg_sel == SEL_ADDR_HI)
        |=> mem_rd && !ready);

    // R8: low data byte writes touch only the low lane
    p_lane_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && reg_wr && reg_sel == SEL_DATA_LO |=> mem_we == 2'b01);

    // R8: high data byte writes touch only the high lane
    p_lane_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && reg_wr && reg_sel == SEL_DATA_HI |=> mem_we == 2'b10);

    // R6: a read returns a byte and starts a refill in the same cycle
    p_read_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !reg_wr && rd_req |=> rd_valid && mem_rd);

    // R10: after a fetch the port is still busy for the capture cycle
    p_fetch_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !ready && !mem_rd && mem_we == 2'b00);

    // R10: no memory activity while the port is idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !mem_rd && mem_we == 2'b00);

    // R10: a control write never makes the port busy
    p_ctrl_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready && reg_wr && reg_sel == SEL_CTRL |=> ready);

endmodule

bind vram_port vp_checker u_vp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .ready    (ready),
    .mem_rd   (mem_rd),
    .mem_we   (mem_we)
);

// File: tb/sim_vram_port.sv
`timescale 1ns/100ps
module sim_vram_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        rd_req = 1'b0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        ready;
    logic [14:0] mem_addr;
    logic        mem_rd;
    logic [1:0]  mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'd0;

    always #2.5 clk = ~clk;

    vram_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_req(rd_req), .rd_hi(rd_hi),
        .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // ---------------- memory (environment) ----------------
    logic [15:0] ram [int];

    function automatic logic [15:0] fill_val(int a);
        return 16'((a * 40503 + 12345) & 16'hFFFF);
    endfunction

    function automatic logic [15:0] ram_get(int a);
        return ram.exists(a) ? ram[a] : fill_val(a);
    endfunction

    always @(posedge clk) begin
        logic [15:0] w;
        if (mem_rd) mem_rdata <= ram_get(int'(mem_addr));
        if (mem_we != 2'b00) begin
            w = ram_get(int'(mem_addr));
            if (mem_we[0]) w[7:0]  = mem_wdata[7:0];
            if (mem_we[1]) w[15:8] = mem_wdata[15:8];
            ram[int'(mem_addr)] = w;
        end
    end

    // ---------------- reference model ----------------
    int vectors = 0;
    int miscompares = 0;
    int m_addr = 0;
    int m_step = 0;
    int m_remap = 0;
    int m_inc_hi = 0;
    int m_hold = 0;
    int shadow [int];
    bit finished = 0;

    function automatic int sh_get(int a);
        return shadow.exists(a) ? shadow[a] : int'(fill_val(a));
    endfunction

    function automatic int step_amount(int code);
        if (code == 0) return 1;
        if (code == 1) return 32;
        return 128;
    endfunction

    function automatic int phys(int a);
        int n, low, rot;
        n = (m_remap == 0) ? 0 : 7 + m_remap;
        if (n == 0) return a & 32'h7FFF;
        low = a % (1 << n);
        rot = ((low << 3) | (low >> (n - 3))) % (1 << n);
        return (a - low + rot) & 32'h7FFF;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bump(bit hi_lane);
        if (int'(hi_lane) == m_inc_hi) m_addr = (m_addr + step_amount(m_step)) & 32'hFFFF;
    endtask

    task automatic expect_refill_tail(string req);
        @(negedge clk);
        chk(req, "ready during capture", int'(ready), 0);
        chk(req, "mem_rd during capture", int'(mem_rd), 0);
        @(negedge clk);
        chk(req, "ready after refill", int'(ready), 1);
    endtask

    task automatic put(logic [2:0] sel, logic [7:0] val, string req);
        int pa;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
        case (sel)
            3'd0: begin
                m_step = int'(val[1:0]); m_remap = int'(val[3:2]); m_inc_hi = int'(val[7]);
                chk("R10", "ready after control write", int'(ready), 1);
                chk("R10", "mem_rd after control write", int'(mem_rd), 0);
            end
            3'd1, 3'd2: begin
                if (sel == 3'd1) m_addr = (m_addr & 32'hFF00) | int'(val);
                else             m_addr = (m_addr & 32'h00FF) | (int'(val) << 8);
                pa = phys(m_addr);
                chk("R10", "ready after address write", int'(ready), 0);
                chk("R5", "fetch strobe", int'(mem_rd), 1);
                chk(req, "fetch address", int'(mem_addr), pa);
                m_hold = sh_get(pa);
                expect_refill_tail("R10");
            end
            default: begin
                pa = phys(m_addr);
                chk("R8", "lane enables", int'(mem_we), (sel == 3'd4) ? 2 : 1);
                chk(req, "write address", int'(mem_addr), pa);
                chk("R8", "write byte", int'(sel == 3'd4 ? mem_wdata[15:8] : mem_wdata[7:0]), int'(val));
                if (sel == 3'd4) shadow[pa] = (sh_get(pa) & 32'h00FF) | (int'(val) << 8);
                else             shadow[pa] = (sh_get(pa) & 32'hFF00) | int'(val);
                bump(sel == 3'd4);
                @(negedge clk);
                chk("R10", "ready after data write", int'(ready), 1);
            end
        endcase
    endtask

    task automatic get(bit hi, string req);
        int pa;
        int expb;
        rd_req = 1'b1; rd_hi = hi;
        @(negedge clk);
        rd_req = 1'b0;
        expb = hi ? ((m_hold >> 8) & 32'hFF) : (m_hold & 32'hFF);
        pa = phys(m_addr);
        chk("R6", "rd_valid", int'(rd_valid), 1);
        chk(req, "read byte", int'(rd_data), expb);
        chk("R6", "refill strobe", int'(mem_rd), 1);
        chk("R6", "refill address", int'(mem_addr), pa);
        m_hold = sh_get(pa);
        bump(hi);
        expect_refill_tail("R10");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "reset ready", int'(ready), 1);
        chk("R10", "reset mem_rd", int'(mem_rd), 0);
        chk("R10", "reset mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // plain addressing, low-lane increment, step 1
        put(3'd0, 8'h00, "R1");
        put(3'd2, 8'h12, "R5");
        put(3'd1, 8'h34, "R5");
        get(1'b0, "R6");             // increments (R2)
        get(1'b1, "R2");             // no increment on high lane
        put(3'd3, 8'hAB, "R2");      // writes 0x1235, increments
        put(3'd4, 8'hCD, "R2");      // writes 0x1236, no increment
        get(1'b0, "R11");            // stale word from before the write
        get(1'b1, "R11");
        put(3'd4, 8'hEE, "R8");
        put(3'd1, 8'h35, "R8");      // re-fetch 0x1235 and verify lane write
        get(1'b0, "R8");
        get(1'b1, "R8");

        // high-lane increment with every step code
        for (int s = 0; s < 4; s++) begin
            put(3'd0, 8'h80 | 8'(s), "R1");
            put(3'd4, 8'(8'h40 + s), "R1");
            put(3'd3, 8'(8'h50 + s), "R2");
            put(3'd4, 8'(8'h60 + s), "R1");
            get(1'b1, "R1");
            get(1'b0, "R2");
        end

        // remap variants with unremapped stepping
        for (int r = 0; r < 4; r++) begin
            put(3'd0, 8'(r << 2), (r == 1) ? "R3" : "R4");
            put(3'd2, 8'h0A, "R4");
            put(3'd1, 8'hF6, (r == 1) ? "R3" : "R4");
            for (int k = 0; k < 5; k++) put(3'd3, 8'(8'h10 * r + k), "R9");
            put(3'd1, 8'hF7, "R9");
            get(1'b0, "R9");
            get(1'b0, "R9");
        end

        // bit 15 ignored, and 16-bit wrap
        put(3'd0, 8'h00, "R7");
        put(3'd2, 8'h83, "R7");
        put(3'd1, 8'h21, "R7");
        put(3'd3, 8'h77, "R7");
        put(3'd2, 8'h03, "R7");
        put(3'd1, 8'h21, "R7");
        get(1'b0, "R7");
        put(3'd2, 8'hFF, "R1");
        put(3'd1, 8'hFF, "R1");
        put(3'd3, 8'h99, "R1");       // wraps to 0x0000
        put(3'd3, 8'h98, "R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule